// File: doc/BRIEF.md
# Audio capture buffer controller

This block takes audio sample words from a capture front end and moves them to memory through a small FIFO. While capture is on, each time the FIFO holds at least a programmed number of words it drains exactly that many words as one burst on a valid/ready write port. Each beat carries the word's address, the data, the burst length and a last flag.

A write pointer walks a ring buffer that starts at a programmed base and is a programmed number of words long. Clearing the capture-enable bit flushes whatever is still in the FIFO as one final burst, and then raises a done flag. The pointer is kept across a disable and re-enable, so capture resumes where it stopped. Only a synchronous soft reset returns the pointer to the base and empties the FIFO.

Software writes the base, size and threshold first and sets capture enable last. The soft reset is sampled on the clock, so the clock must be running while it is held.

Top module: `acap_buf_ctrl`

## Requirements
- R1: After the hardware reset `rst_ni` is released, `mem_valid_o`, `done_o` and `smp_ready_o` are 0 and `mem_addr_o` equals `base_i`.
- R2: A control write sets capture enable from bit 30 of `ctrl_wdata_i`, and all other bits are ignored. `smp_ready_o` is 1 only while capture is enabled and the FIFO is not full. Samples offered while `smp_ready_o` is 0 are discarded.
- R3: When capture is enabled, no burst is running and the FIFO fill is at least `thresh_i` (and `thresh_i` is not 0), a burst of exactly `thresh_i` beats starts on the next cycle. `mem_len_o` equals `thresh_i`, and `mem_last_o` is 1 only on the final beat.
- R4: While `mem_valid_o` is 1 and `mem_ready_i` is 0, the address, data and length hold steady and the beat stays pending.
- R5: Each accepted beat advances `mem_addr_o` by one word. After the word at `base_i + size_i - 1`, the address returns to `base_i`.
- R6: A control write that clears capture enable flushes every word left in the FIFO as one burst whose length is the fill at its start. `done_o` rises on the cycle after the flush burst's last beat is accepted.
- R7: Clearing capture enable with an empty FIFO sets `done_o` within two cycles, and no write beat is issued.
- R8: Setting capture enable again without a soft reset clears `done_o`, and writing continues from the address where the last burst stopped.
- R9: A one-cycle `soft_rst_i` empties the FIFO, aborts any burst, clears capture enable and `done_o`, and returns `mem_addr_o` to `base_i`.
- R10: A sample pushed in the same cycle as a beat is popped is stored, and the FIFO delivers words to memory in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data, bit 30 = capture enable |
| base_i | input | AW | Buffer base word address |
| size_i | input | AW | Buffer length in words (at least 1) |
| thresh_i | input | CW | FIFO fill that triggers a burst |
| smp_valid_i | input | 1 | Sample word offered |
| smp_data_i | input | DW | Sample word |
| smp_ready_o | output | 1 | Sample can be accepted |
| mem_valid_o | output | 1 | Write beat valid |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_addr_o | output | AW | Word address of the beat |
| mem_data_o | output | DW | Beat data |
| mem_len_o | output | CW | Beats in the current burst |
| mem_last_o | output | 1 | Final beat of the burst |
| done_o | output | 1 | A flush has fully drained the FIFO |

## Verification
Two pairs of events can fall in the same clock edge. The first is a sample push together with a beat pop. The bench provokes it by feeding samples back to back while a threshold burst drains. The second is a capture-disable write together with a running threshold burst, provoked by writing the control register in the middle of a burst, with `mem_ready_i` toggling. A behavioural queue model, stepped each edge, predicts every output. Any lost word, wrong burst length, early flush or wrong done timing shows up as a mismatch on the next falling edge.

// File: rtl/acap_pkg.sv
package acap_pkg;
  typedef enum logic {XF_IDLE, XF_BUSY} xfer_st_e;
  localparam int unsigned CAP_EN_BIT = 30;
endpackage

// File: rtl/acap_fifo.sv
module acap_fifo #(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] inc_ptr(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= inc_ptr(wr_q);
      if (do_pop)  rd_q <= inc_ptr(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // storage needs no reset
  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/acap_ptr.sv
module acap_ptr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] off_q;
  logic [AW:0]   off_inc;

  assign off_inc = {1'b0, off_q} + 1'b1;
  assign addr_o  = base_i + off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (clr_i)  off_q <= '0;
    else if (adv_i)  off_q <= (off_inc >= {1'b0, size_i}) ? '0 : off_inc[AW-1:0];
  end
endmodule

// File: rtl/acap_ctrl.sv
module acap_ctrl
  import acap_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          cap_wr_i,
  input  logic          cap_val_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          fire_i,
  output logic          busy_o,
  output logic [CW-1:0] len_o,
  output logic          last_o,
  output logic          cap_o,
  output logic          done_o
);
  xfer_st_e      st_q;
  logic [CW-1:0] len_q, left_q;
  logic          cap_q, fpend_q, fburst_q, done_q;
  logic          thr_hit;

  assign thr_hit = cap_q && (thresh_i != '0) && (count_i >= thresh_i);
  assign busy_o  = (st_q == XF_BUSY);
  assign len_o   = len_q;
  assign last_o  = busy_o && (left_q == CW'(1));
  assign cap_o   = cap_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= XF_IDLE;
      len_q    <= '0;
      left_q   <= '0;
      cap_q    <= 1'b0;
      fpend_q  <= 1'b0;
      fburst_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (soft_rst_i) begin
      st_q     <= XF_IDLE;
      len_q    <= '0;
      left_q   <= '0;
      cap_q    <= 1'b0;
      fpend_q  <= 1'b0;
      fburst_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      unique case (st_q)
        XF_IDLE: begin
          if (fpend_q && count_i == '0) begin
            fpend_q <= 1'b0;
            done_q  <= 1'b1;
          end else if (fpend_q) begin
            // flush takes precedence over a threshold burst
            st_q     <= XF_BUSY;
            len_q    <= count_i;
            left_q   <= count_i;
            fburst_q <= 1'b1;
          end else if (thr_hit) begin
            st_q     <= XF_BUSY;
            len_q    <= thresh_i;
            left_q   <= thresh_i;
            fburst_q <= 1'b0;
          end
        end
        XF_BUSY: begin
          if (fire_i) begin
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) begin
              st_q <= XF_IDLE;
              if (fburst_q) begin
                fpend_q <= 1'b0;
                done_q  <= 1'b1;
              end
            end
          end
        end
        default: st_q <= XF_IDLE;
      endcase
      if (cap_wr_i) begin
        cap_q <= cap_val_i;
        if (cap_q && !cap_val_i) fpend_q <= 1'b1;
        if (!cap_q && cap_val_i) done_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acap_buf_ctrl.sv
module acap_buf_ctrl
  import acap_pkg::*;
#(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          ctrl_wr_i,
  input  logic [31:0]   ctrl_wdata_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  output logic          smp_ready_o,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic [CW-1:0] mem_len_o,
  output logic          mem_last_o,
  output logic          done_o
);
  logic [CW-1:0] fill;
  logic          full, cap_en, fire;

  assign fire        = mem_valid_o && mem_ready_i;
  assign smp_ready_o = cap_en && !full;

  acap_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_rst_i),
    .push_i  (smp_valid_i && smp_ready_o),
    .data_i  (smp_data_i),
    .pop_i   (fire),
    .data_o  (mem_data_o),
    .count_o (fill),
    .full_o  (full)
  );

  acap_ptr #(.AW(AW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_rst_i),
    .adv_i   (fire),
    .base_i  (base_i),
    .size_i  (size_i),
    .addr_o  (mem_addr_o)
  );

  acap_ctrl #(.CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .cap_wr_i   (ctrl_wr_i),
    .cap_val_i  (ctrl_wdata_i[CAP_EN_BIT]),
    .count_i    (fill),
    .thresh_i   (thresh_i),
    .fire_i     (fire),
    .busy_o     (mem_valid_o),
    .len_o      (mem_len_o),
    .last_o     (mem_last_o),
    .cap_o      (cap_en),
    .done_o     (done_o)
  );
endmodule

// File: rtl/acap_buf_ctrl_chk.sv
module acap_buf_ctrl_chk #(
  parameter int unsigned DW = 24,
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          soft_rst_i,
  input logic          ctrl_wr_i,
  input logic [31:0]   ctrl_wdata_i,
  input logic [AW-1:0] base_i,
  input logic          smp_ready_o,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_o,
  input logic [CW-1:0] mem_len_o,
  input logic          mem_last_o,
  input logic          done_o
);
  logic [CW:0] beat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 beat_cnt <= '0;
    else if (soft_rst_i)                         beat_cnt <= '0;
    else if (mem_valid_o && mem_ready_i)         beat_cnt <= mem_last_o ? '0 : beat_cnt + 1'b1;
  end

  a_r3_last_matches_len: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    (mem_valid_o && mem_last_o) |-> (beat_cnt + 1'b1 == {1'b0, mem_len_o}));

  a_r4_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o) && $stable(mem_len_o)));

  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    (mem_valid_o && mem_ready_i) |=>
      ((mem_addr_o == $past(mem_addr_o) + 1'b1) || (mem_addr_o == base_i)));

  a_r2_off_blocks_samples: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    (ctrl_wr_i && !ctrl_wdata_i[30]) |=> !smp_ready_o);

  a_r6_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    $rose(done_o) |-> !mem_valid_o);

  a_r9_soft_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!mem_valid_o && !done_o && !smp_ready_o && mem_addr_o == base_i));
endmodule

bind acap_buf_ctrl acap_buf_ctrl_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .ctrl_wr_i    (ctrl_wr_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .base_i       (base_i),
  .smp_ready_o  (smp_ready_o),
  .mem_valid_o  (mem_valid_o),
  .mem_ready_i  (mem_ready_i),
  .mem_addr_o   (mem_addr_o),
  .mem_data_o   (mem_data_o),
  .mem_len_o    (mem_len_o),
  .mem_last_o   (mem_last_o),
  .done_o       (done_o)
);

// File: tb/tb_acap_buf_ctrl.sv
module tb_acap_buf_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BASE = 'h100;
  localparam int SIZE = 6;
  localparam int THR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic mem_ready = 1'b0;
  logic smp_ready, mem_valid, mem_last, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [CW-1:0] mem_len;

  int checks = 0, errors = 0, beats = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acap_buf_ctrl #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .base_i(AW'(BASE)), .size_i(AW'(SIZE)), .thresh_i(CW'(THR)),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .smp_ready_o(smp_ready),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .mem_len_o(mem_len), .mem_last_o(mem_last), .done_o(done)
  );

  // behavioural reference
  int q[$];
  bit m_busy, m_cap, m_fpend, m_fb, m_done;
  int m_left, m_len, m_off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_cap = 0; m_fpend = 0; m_fb = 0; m_done = 0;
      m_left = 0; m_len = 0; m_off = 0;
    end else if (soft_rst) begin
      q.delete(); m_busy = 0; m_cap = 0; m_fpend = 0; m_fb = 0; m_done = 0;
      m_left = 0; m_len = 0; m_off = 0;
    end else begin
      bit o_cap, o_fp, o_busy, fire, push;
      int o_cnt;
      o_cap = m_cap; o_fp = m_fpend; o_busy = m_busy; o_cnt = q.size();
      fire = o_busy && mem_ready;
      push = smp_valid && o_cap && (o_cnt < DEPTH);
      if (fire) begin
        void'(q.pop_front());
        m_off = (m_off + 1 >= SIZE) ? 0 : m_off + 1;
      end
      if (push) q.push_back(int'(smp_data));
      if (o_busy) begin
        if (fire) begin
          if (m_left == 1) begin
            m_busy = 0;
            if (m_fb) begin m_fpend = 0; m_done = 1; end
          end
          m_left--;
        end
      end else if (o_fp && o_cnt == 0) begin
        m_fpend = 0; m_done = 1;
      end else if (o_fp) begin
        m_busy = 1; m_len = o_cnt; m_left = o_cnt; m_fb = 1;
      end else if (o_cap && o_cnt >= THR) begin
        m_busy = 1; m_len = THR; m_left = THR; m_fb = 0;
      end
      if (ctrl_wr) begin
        if (o_cap && !ctrl_wdata[30]) m_fpend = 1;
        if (!o_cap && ctrl_wdata[30]) m_done = 0;
        m_cap = ctrl_wdata[30];
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 mem_valid", int'(mem_valid), int'(m_busy));
      chk("R2 smp_ready", int'(smp_ready), int'(m_cap && q.size() < DEPTH));
      chk("R6 done", int'(done), int'(m_done));
      chk("R5 addr", int'(mem_addr), BASE + m_off);
      if (m_busy) begin
        chk("R3 len", int'(mem_len), m_len);
        chk("R3 last", int'(mem_last), int'(m_left == 1));
        chk("R10 data", int'(mem_data), q[0]);
      end
      if (mem_valid && mem_ready) beats++;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_ctrl(logic [31:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v; tick(); ctrl_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b0;
    tick(3); rst_n = 1'b1; tick();
    // R1
    chk("R1 valid", int'(mem_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ready", int'(smp_ready), 0);
    chk("R1 addr", int'(mem_addr), BASE);
    // R2: every bit but 30 set, capture stays off
    wr_ctrl(32'hBFFF_FFFF);
    smp_valid = 1'b1; smp_data = 24'hDEAD; tick(); smp_valid = 1'b0; tick();
    chk("R2 ignored", int'(smp_ready), 0);
    chk("R2 no beat", int'(mem_valid), 0);
    wr_ctrl(32'h4000_0000);
    chk("R2 enabled", int'(smp_ready), 1);
    // R3/R10/R5: stream with concurrent push/pop, wrap after 6 words
    mem_ready = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      smp_valid = 1'b1; smp_data = DW'(i * 17); tick();
    end
    smp_valid = 1'b0;
    // R4: stalls with data still queued
    for (int i = 0; i < 12; i++) begin mem_ready = i[0]; tick(); end
    mem_ready = 1'b1; tick(4);
    chk("R10 residue", q.size(), 1);
    // R6: disable during a threshold burst, then flush the rest
    for (int i = 20; i < 25; i++) begin
      smp_valid = 1'b1; smp_data = DW'(i); mem_ready = 1'b0; tick();
    end
    smp_valid = 1'b0; mem_ready = 1'b1; tick(2);
    wr_ctrl(32'h0);
    tick(12);
    chk("R6 done after flush", int'(done), 1);
    chk("R6 fifo drained", q.size(), 0);
    // R8: re-enable resumes pointer, done cleared
    b0 = int'(mem_addr);
    wr_ctrl(32'h4000_0000);
    chk("R8 done cleared", int'(done), 0);
    chk("R8 addr kept", int'(mem_addr), b0);
    // R7: empty flush
    b0 = beats;
    wr_ctrl(32'h0); tick(2);
    chk("R7 done", int'(done), 1);
    chk("R7 no beat", beats, b0);
    // R9: soft reset with data queued and a burst running
    wr_ctrl(32'h4000_0000);
    mem_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin smp_valid = 1'b1; smp_data = DW'(i + 40); tick(); end
    smp_valid = 1'b0;
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    chk("R9 addr base", int'(mem_addr), BASE);
    chk("R9 valid", int'(mem_valid), 0);
    chk("R9 cap off", int'(smp_ready), 0);
    mem_ready = 1'b1; tick(3);
    chk("R9 no beat after", int'(mem_valid), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule